// File: doc/BRIEF.md
# Up-Counting Compare Timer with Output Pin

This block is a register-programmed timer built around an up-counter that advances on a functional-clock tick. The tick can pass straight through, or it can be divided by a power of two. When the count passes its all-ones value, the counter either reloads from a load register and keeps running, or it stops and clears. When compare is enabled, a match register flags the tick on which the count reaches it. Overflow and match events can drive an output pin, either as a level toggle or as a single-cycle pulse. When no events are selected, the pin rests at a programmable idle level.

Each event can set a status flag and raise the interrupt line if its interrupt enable is set. A separate wake-up mask turns each event into a one-cycle wake-up pulse, whatever the interrupt enables hold. Software reaches the block through a simple strobe interface: one write strobe and one read strobe, with a word address and data. Read data appears one cycle after the read strobe. A soft reset input returns every register to zero.

Top module: `uptick_timer`

## Requirements
- R1: While started, the count goes up by one on every counting step. A write to the count register (address 5) sets the count. With no step and no write, the count holds.
- R2: A step taken at count 0xFFFFFFFF is an overflow. If auto-reload (control bit 1) is set, the count takes the load register (address 6) and the counter keeps running.
- R3: On overflow with auto-reload clear, the count becomes 0 and the start bit (control bit 0) reads back as 0.
- R4: With prescale enable (control bit 5) set, a step is taken once every 2^(P+1) ticks, where P is control bits 4:2. With it clear, every tick is a step. The divider restarts from zero after any register write and while the counter is stopped.
- R5: A match event occurs only when compare enable (control bit 6) is set and an increment step makes the count equal the match register (address 8). A reload does not cause a match.
- R6: Trigger mode (control bits 11:10) selects the pin events: 0 gives none, 1 gives overflow only, 2 gives overflow and match. Mode 3 behaves like mode 0.
- R7: With control bit 12 set, each pin event inverts the pin. With it clear, each event drives the pin to the inverse of the idle level for exactly one cycle.
- R8: The pin enable `pin_oe` is the inverse of control bit 14. When bit 14 is 1 the pin holds its value. Otherwise, while stopped or in mode 0 or 3, the pin equals the idle level (control bit 7) from the next cycle on.
- R9: Status (address 2) has bit 0 for match, bit 1 for overflow and bit 2 for capture, which never sets here. A bit sets only if its enable in address 3 is 1. Writing 1 clears a bit. `irq_o` is high while any status bit is 1.
- R10: The wake-up mask (address 4) uses the same bit order. `wake_o` pulses for one cycle after each cycle that has an event enabled in the mask, regardless of the interrupt enables.
- R11: A write to address 7 copies the load register into the count. Reading address 7 returns 0xFFFFFFFF.
- R12: `soft_rst` or `rst_n` low clears the control, status, enable, wake-up, load, match and count registers and the pin. Address 0 reads 0x21.
- R13: A tick that coincides with any register write is dropped: it neither increments the count nor advances the divider.
- R14: The control register (address 1) keeps bits 14:0 as written and reads them back. Bits 9:8 and 13 are stored but have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| tick_en | input | 1 | Functional-clock tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| count_o | output | 32 | Current count |
| pin_o | output | 1 | Event output pin level |
| pin_oe | output | 1 | Pin output enable |
| irq_o | output | 1 | Interrupt line |
| wake_o | output | 1 | Wake-up pulse |

## Verification
The hardest situation to reach from the ports is an event landing on a chosen divider phase while the pin is in a particular mode. Overflow needs 2^32 steps from reset. The stimulus therefore writes the count to within a few steps of the top, or of the match value, and then releases a counted number of ticks. That makes overflow, match and reload fall on known cycles. A long phase then applies irregular ticks with the divider active and both event types armed, so that pulses, toggles and status updates land on varying divider phases. Throughout, a behavioural model is compared against the outputs on every cycle.

// File: rtl/uptick_pkg.sv
// Package: shared register addresses, control word layout and event
// indices for the up-counting compare timer.
package uptick_pkg;

    localparam int ADDR_W = 4;
    localparam int PTV_W  = 3;
    localparam int CTRL_W = 15;
    localparam int NUM_EV = 3;

    // Event indices, shared by status, interrupt enable and wake mask
    localparam int EV_MAT = 0;
    localparam int EV_OVF = 1;
    localparam int EV_CAP = 2;

    // Register word addresses
    localparam logic [ADDR_W-1:0] A_REV    = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd1;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_IEN    = 4'd3;
    localparam logic [ADDR_W-1:0] A_WEN    = 4'd4;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd5;
    localparam logic [ADDR_W-1:0] A_LOAD   = 4'd6;
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd7;
    localparam logic [ADDR_W-1:0] A_MATCH  = 4'd8;

    localparam logic [31:0] REV_VALUE = 32'h0000_0021;

    typedef enum logic [1:0] {
        TRG_OFF  = 2'd0,
        TRG_OVF  = 2'd1,
        TRG_BOTH = 2'd2,
        TRG_RSVD = 2'd3
    } trig_e;

    // Control word, MSB first; bit positions are software-visible
    typedef struct packed {
        logic              dir_in;   // 14
        logic              cap_sel;  // 13 (stored only)
        logic              toggle;   // 12
        trig_e             trig;     // 11:10
        logic [1:0]        cap_mode; // 9:8 (stored only)
        logic              idle_lvl; // 7
        logic              cmp_en;   // 6
        logic              psc_en;   // 5
        logic [PTV_W-1:0]  psc_val;  // 4:2
        logic              reload;   // 1
        logic              run;      // 0
    } ctrl_t;

endpackage

// File: rtl/uptick_prescale.sv
// Module: uptick_prescale
// Turns qualified ticks into counting steps: passes them straight through,
// or divides by 2^(psc_val+1). Assumes tick is already gated by run state
// and write priority; clr restarts the division phase.
module uptick_prescale #(
    parameter int PTV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             psc_en,
    input  logic [PTV_W-1:0] psc_val,
    output logic             step
);
    localparam int PSC_W = 1 << PTV_W;

    logic [PSC_W-1:0] phase_q;
    logic [PSC_W-1:0] limit;

    // Terminal phase value for the selected division ratio
    always_comb begin
        limit = ~({PSC_W{1'b1}} << ({1'b0, psc_val} + 4'd1));
    end

    // Step on every tick, or on the tick that reaches the terminal phase
    always_comb begin
        step = tick & (~psc_en | (phase_q == limit));
    end

    // Phase counter: cleared on request, advanced by each tick
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= step ? '0 : phase_q + 1'b1;
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        psc_en |-> (phase_q <= limit)); // R4

endmodule

// File: rtl/uptick_core.sv
// Module: uptick_core
// Holds the count. Applies register writes first, then overflow handling,
// then increments, and flags overflow and match events for the step taken
// this cycle. Assumes step is never high in a cycle with a write.
module uptick_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             step,
    input  logic             cmp_en,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    input  logic             wr_count,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             mat_evt
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic             at_top;

    // Next increment value and terminal-count detect
    always_comb begin
        count_inc = count_q + 1'b1;
        at_top    = &count_q;
    end

    // Events of the step taken this cycle
    always_comb begin
        ovf_evt = step & at_top;
        mat_evt = step & ~at_top & cmp_en & (count_inc == match_val);
    end

    // Count register with write priority over stepping
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            count_q <= '0;
        end else if (wr_count) begin
            count_q <= wdata;
        end else if (wr_reload) begin
            count_q <= load_val;
        end else if (ovf_evt) begin
            count_q <= reload ? load_val : '0;
        end else if (step) begin
            count_q <= count_inc;
        end
    end

    assign count = count_q;

    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && reload && !srst) |=> (count_q == $past(load_val))); // R2
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !reload && !srst) |=> (count_q == '0)); // R3
    AST_MATCH_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mat_evt && !srst) |=> (count_q == $past(match_val))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_count && !wr_reload && !srst) |=> $stable(count_q)); // R1

endmodule

// File: rtl/uptick_pin.sv
// Module: uptick_pin
// Drives the event output pin from overflow and match events by trigger
// mode, as a toggle or a one-cycle pulse, or parks it at the idle level.
// Assumes the events belong to the current cycle's step.
module uptick_pin
    import uptick_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  srst,
    input  logic  run,
    input  logic  idle_lvl,
    input  trig_e trig,
    input  logic  toggle,
    input  logic  dir_in,
    input  logic  ovf_evt,
    input  logic  mat_evt,
    output logic  pin_o,
    output logic  pin_oe
);
    logic pin_q;
    logic parked;
    logic fire;

    // Pin event selection and parking condition
    always_comb begin
        parked = ~run | (trig == TRG_OFF) | (trig == TRG_RSVD);
        fire   = ((trig == TRG_OVF) & ovf_evt) |
                 ((trig == TRG_BOTH) & (ovf_evt | mat_evt));
    end

    // Pin level register
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            pin_q <= 1'b0;
        end else if (dir_in) begin
            pin_q <= pin_q;
        end else if (parked) begin
            pin_q <= idle_lvl;
        end else if (toggle) begin
            pin_q <= fire ? ~pin_q : pin_q;
        end else begin
            pin_q <= fire ? ~idle_lvl : idle_lvl;
        end
    end

    assign pin_o  = pin_q;
    assign pin_oe = ~dir_in;

    AST_PIN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (parked && !dir_in && !srst) |=> (pin_q == $past(idle_lvl))); // R8
    AST_PIN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_in && !srst) |=> $stable(pin_q)); // R8
    AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && toggle && !parked && !dir_in && !srst) |=> (pin_q != $past(pin_q))); // R7
    AST_PIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !toggle && !parked && !dir_in && !srst) |=> (pin_q == !$past(idle_lvl))); // R7

endmodule

// File: rtl/uptick_regs.sv
// Module: uptick_regs
// Register file: control, enables, load, match, write-one-to-clear status,
// the wake-up pulse and registered read data. Assumes one access per cycle
// and that the event inputs belong to the current cycle.
module uptick_regs
    import uptick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf_evt,
    input  logic              mat_evt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  match_val,
    output logic              wr_count,
    output logic              wr_reload,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq_o,
    output logic              wake_o
);
    ctrl_t             ctrl_q;
    logic [NUM_EV-1:0] ien_q;
    logic [NUM_EV-1:0] wen_q;
    logic [NUM_EV-1:0] stat_q;
    logic [NUM_EV-1:0] ev;
    logic [NUM_EV-1:0] w1c;
    logic [CNT_W-1:0]  load_q;
    logic [CNT_W-1:0]  match_q;
    logic [CNT_W-1:0]  rdata_q;
    logic              wake_q;
    logic              wr_ctrl;

    // Write decode and event vector
    always_comb begin
        wr_ctrl      = wr_en && (addr == A_CTRL);
        wr_count     = wr_en && (addr == A_COUNT);
        wr_reload    = wr_en && (addr == A_RELOAD);
        w1c          = (wr_en && (addr == A_STAT)) ? wdata[NUM_EV-1:0] : '0;
        ev           = '0;
        ev[EV_MAT]   = mat_evt;
        ev[EV_OVF]   = ovf_evt;
    end

    // Control word; a stopping overflow clears the run bit
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end else if (ovf_evt && !ctrl_q.reload) begin
            ctrl_q.run <= 1'b0;
        end
    end

    // Enables, load and match registers
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ien_q   <= '0;
            wen_q   <= '0;
            load_q  <= '0;
            match_q <= '0;
        end else if (wr_en) begin
            if (addr == A_IEN)   ien_q   <= wdata[NUM_EV-1:0];
            if (addr == A_WEN)   wen_q   <= wdata[NUM_EV-1:0];
            if (addr == A_LOAD)  load_q  <= wdata;
            if (addr == A_MATCH) match_q <= wdata;
        end
    end

    // One status flag per event source
    for (genvar i = 0; i < NUM_EV; i++) begin : g_stat
        // Flag: set by an enabled event, cleared by a one written to it
        always_ff @(posedge clk) begin
            if (!rst_n || srst) begin
                stat_q[i] <= 1'b0;
            end else begin
                stat_q[i] <= (stat_q[i] & ~w1c[i]) | (ev[i] & ien_q[i]);
            end
        end

        AST_STAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[i]) |-> $past(ien_q[i])); // R9
    end

    // Wake-up pulse from masked events
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            wake_q <= 1'b0;
        end else begin
            wake_q <= |(ev & wen_q);
        end
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            case (addr)
                A_REV:    rdata_q <= CNT_W'(REV_VALUE);
                A_CTRL:   rdata_q <= CNT_W'(ctrl_q);
                A_STAT:   rdata_q <= CNT_W'(stat_q);
                A_IEN:    rdata_q <= CNT_W'(ien_q);
                A_WEN:    rdata_q <= CNT_W'(wen_q);
                A_COUNT:  rdata_q <= count;
                A_LOAD:   rdata_q <= load_q;
                A_RELOAD: rdata_q <= '1;
                A_MATCH:  rdata_q <= match_q;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign ctrl      = ctrl_q;
    assign load_val  = load_q;
    assign match_val = match_q;
    assign rdata     = rdata_q;
    assign irq_o     = |stat_q;
    assign wake_o    = wake_q;

    AST_W1C_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[EV_OVF] && !ovf_evt && !srst) |=> !stat_q[EV_OVF]); // R9
    AST_WAKE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> $past(|(ev & wen_q))); // R10
    AST_AUTO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !ctrl_q.reload && !wr_ctrl && !srst) |=> !ctrl_q.run); // R3
    AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_q[EV_CAP]); // R9

endmodule

// File: rtl/uptick_timer.sv
// Module: uptick_timer (top)
// Up-counting compare timer: register file, tick divider, counter core and
// event pin. A register write cycle drops any coinciding tick. Assumes
// tick_en is synchronous to clk.
module uptick_timer
    import uptick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [CNT_W-1:0]  count_o,
    output logic              pin_o,
    output logic              pin_oe,
    output logic              irq_o,
    output logic              wake_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] match_val;
    logic             wr_count;
    logic             wr_reload;
    logic             ovf_evt;
    logic             mat_evt;
    logic             qual_tick;
    logic             psc_clr;
    logic             step;

    // Tick qualification: running, and no register write this cycle
    always_comb begin
        qual_tick = tick_en & ~wr_en & ctrl.run;
        psc_clr   = ~ctrl.run | wr_en | soft_rst;
    end

    uptick_regs #(.CNT_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (soft_rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .count     (count_o),
        .ovf_evt   (ovf_evt),
        .mat_evt   (mat_evt),
        .ctrl      (ctrl),
        .load_val  (load_val),
        .match_val (match_val),
        .wr_count  (wr_count),
        .wr_reload (wr_reload),
        .rdata     (rdata),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    uptick_prescale #(.PTV_W(PTV_W)) i_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (psc_clr),
        .tick    (qual_tick),
        .psc_en  (ctrl.psc_en),
        .psc_val (ctrl.psc_val),
        .step    (step)
    );

    uptick_core #(.CNT_W(CNT_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (soft_rst),
        .step      (step),
        .cmp_en    (ctrl.cmp_en),
        .reload    (ctrl.reload),
        .load_val  (load_val),
        .match_val (match_val),
        .wr_count  (wr_count),
        .wr_reload (wr_reload),
        .wdata     (wdata),
        .count     (count_o),
        .ovf_evt   (ovf_evt),
        .mat_evt   (mat_evt)
    );

    uptick_pin i_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (soft_rst),
        .run      (ctrl.run),
        .idle_lvl (ctrl.idle_lvl),
        .trig     (ctrl.trig),
        .toggle   (ctrl.toggle),
        .dir_in   (ctrl.dir_in),
        .ovf_evt  (ovf_evt),
        .mat_evt  (mat_evt),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe)
    );

    AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !step); // R13

endmodule

// File: tb/test_uptick_timer.sv
// Bench: behavioural per-cycle model compared against the outputs.
module test_uptick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, count_o;
    logic        pin_o, pin_oe, irq_o, wake_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    started = 0;
    string cur_req = "R12";

    always #5 clk = ~clk;

    uptick_timer i_uptick_timer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick_en(tick_en),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .count_o(count_o), .pin_o(pin_o), .pin_oe(pin_oe),
        .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_cnt, m_load, m_match, m_rdata;
    logic [14:0] m_ctrl;
    logic [2:0]  m_stat, m_ie, m_we, m_ev;
    logic        m_pin, m_wake;
    int          m_psc;

    always @(posedge clk) begin
        bit stp, ovf, mat, run, fire;
        int lim;
        logic [1:0] trg;
        logic [2:0] clr;
        if (!rst_n || soft_rst) begin
            m_cnt = 0; m_load = 0; m_match = 0; m_rdata = 0; m_ctrl = 0;
            m_stat = 0; m_ie = 0; m_we = 0; m_pin = 0; m_wake = 0; m_psc = 0;
        end else begin
            run = m_ctrl[0];
            stp = 0;
            if (!run || wr_en) m_psc = 0;
            else if (tick_en) begin
                if (m_ctrl[5]) begin
                    lim = (1 << (int'(m_ctrl[4:2]) + 1)) - 1;
                    if (m_psc == lim) begin stp = 1; m_psc = 0; end
                    else m_psc = m_psc + 1;
                end else stp = 1;
            end
            ovf = stp && (m_cnt == 32'hFFFF_FFFF);
            mat = stp && !ovf && m_ctrl[6] && ((m_cnt + 32'd1) == m_match);
            m_ev = {1'b0, ovf, mat};
            trg = m_ctrl[11:10];
            fire = (ovf && (trg == 2'd1 || trg == 2'd2)) || (mat && trg == 2'd2);
            if (m_ctrl[14]) m_pin = m_pin;
            else if (!run || trg == 2'd0 || trg == 2'd3) m_pin = m_ctrl[7];
            else if (m_ctrl[12]) m_pin = fire ? ~m_pin : m_pin;
            else m_pin = fire ? ~m_ctrl[7] : m_ctrl[7];
            m_wake = |(m_ev & m_we);
            clr = (wr_en && addr == 4'd2) ? wdata[2:0] : 3'd0;
            if (rd_en) begin
                case (addr)
                    4'd0: m_rdata = 32'h21;
                    4'd1: m_rdata = {17'd0, m_ctrl};
                    4'd2: m_rdata = {29'd0, m_stat};
                    4'd3: m_rdata = {29'd0, m_ie};
                    4'd4: m_rdata = {29'd0, m_we};
                    4'd5: m_rdata = m_cnt;
                    4'd6: m_rdata = m_load;
                    4'd7: m_rdata = 32'hFFFF_FFFF;
                    4'd8: m_rdata = m_match;
                    default: m_rdata = 0;
                endcase
            end
            m_stat = (m_stat & ~clr) | (m_ev & m_ie);
            if (wr_en && addr == 4'd5) m_cnt = wdata;
            else if (wr_en && addr == 4'd7) m_cnt = m_load;
            else if (ovf) begin
                m_cnt = m_ctrl[1] ? m_load : 32'd0;
                if (!m_ctrl[1]) m_ctrl[0] = 1'b0;
            end else if (stp) m_cnt = m_cnt + 32'd1;
            if (wr_en) begin
                case (addr)
                    4'd1: m_ctrl = wdata[14:0];
                    4'd3: m_ie = wdata[2:0];
                    4'd4: m_we = wdata[2:0];
                    4'd6: m_load = wdata;
                    4'd8: m_match = wdata;
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk(count_o == m_cnt, cur_req, "count", count_o, m_cnt);
            chk(pin_o == m_pin, cur_req, "pin", {31'd0, pin_o}, {31'd0, m_pin});
            chk(pin_oe == !m_ctrl[14], cur_req, "pin_oe", {31'd0, pin_oe}, {31'd0, !m_ctrl[14]});
            chk(irq_o == |m_stat, cur_req, "irq", {31'd0, irq_o}, {31'd0, |m_stat});
            chk(wake_o == m_wake, cur_req, "wake", {31'd0, wake_o}, {31'd0, m_wake});
            chk(rdata == m_rdata, cur_req, "rdata", rdata, m_rdata);
        end
    end

    // ---------------- stimulus (tasks are entered at a falling edge) -------
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0;
        v = rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        // R12: reset state and revision
        cur_req = "R12";
        chk(count_o == 0 && pin_o == 0 && irq_o == 0, "R12", "reset outputs",
            {count_o[29:0], pin_o, irq_o}, 32'd0);
        rd(4'd0, v); chk(v == 32'h21, "R12", "revision", v, 32'h21);

        // R14: control readback, stopped
        cur_req = "R14";
        wr(4'd1, 32'h7FFE); rd(4'd1, v); chk(v == 32'h7FFE, "R14", "ctrl readback", v, 32'h7FFE);
        wr(4'd1, 32'h0);

        // R1: plain counting
        cur_req = "R1";
        wr(4'd5, 32'd10); wr(4'd1, 32'h1); ticks(20);
        rd(4'd5, v); chk(v == 32'd30, "R1", "count after 20 steps", v, 32'd30);

        // R4: divide by 4
        cur_req = "R4";
        wr(4'd1, 32'h0); wr(4'd5, 32'd0); wr(4'd1, 32'h1 | (1 << 5) | (1 << 2));
        ticks(40);
        rd(4'd5, v); chk(v == 32'd10, "R4", "divided count", v, 32'd10);
        wr(4'd1, 32'h1 | (1 << 5) | (7 << 2)); ticks(600);

        // R2: reload on overflow, toggle pin, R9 interrupt
        cur_req = "R2";
        wr(4'd1, 32'h0); wr(4'd6, 32'h100); wr(4'd3, 32'h7); wr(4'd4, 32'h2);
        wr(4'd5, 32'hFFFF_FFF0); wr(4'd1, 32'h1 | 32'h2 | (1 << 10) | (1 << 12));
        ticks(16);
        rd(4'd5, v); chk(v == 32'h100, "R2", "reloaded count", v, 32'h100);
        chk(pin_o == 1'b1, "R7", "toggled pin", {31'd0, pin_o}, 32'd1);
        cur_req = "R9";
        chk(irq_o == 1'b1, "R9", "irq after overflow", {31'd0, irq_o}, 32'd1);
        wr(4'd2, 32'h2);
        chk(irq_o == 1'b0, "R9", "irq after clear", {31'd0, irq_o}, 32'd0);

        // R5/R6/R7: match and overflow pulses in mode 2
        cur_req = "R5";
        wr(4'd1, 32'h0); wr(4'd8, 32'hFFFF_FFF8); wr(4'd5, 32'hFFFF_FFF0);
        wr(4'd1, 32'h1 | 32'h2 | (1 << 6) | (2 << 10)); ticks(30);
        rd(4'd2, v); chk(v[0] == 1'b1, "R5", "match status", v, 32'h3);
        wr(4'd2, 32'h7); wr(4'd5, 32'hFFFF_FFF0);
        wr(4'd1, 32'h1 | 32'h2 | (2 << 10)); ticks(12);
        rd(4'd2, v); chk(v == 32'd0, "R5", "no match without compare", v, 32'd0);

        // R6: mode 3 acts as none, pin parked at idle level 1
        cur_req = "R6";
        wr(4'd1, 32'h1 | 32'h2 | (1 << 6) | (3 << 10) | (1 << 7)); ticks(40);
        chk(pin_o == 1'b1, "R6", "mode 3 parked", {31'd0, pin_o}, 32'd1);
        wr(4'd5, 32'hFFFF_FFFA); wr(4'd1, 32'h1 | 32'h2 | (1 << 10) | (1 << 7)); ticks(20);

        // R3: stop and clear without reload
        cur_req = "R3";
        wr(4'd1, 32'h0); wr(4'd5, 32'hFFFF_FFFC);
        wr(4'd1, 32'h1 | (1 << 10) | (1 << 12)); ticks(10);
        rd(4'd1, v); chk(v[0] == 1'b0, "R3", "start bit cleared", v, 32'h1400);
        rd(4'd5, v); chk(v == 32'd0, "R3", "cleared count", v, 32'd0);

        // R8: pin as input is frozen and not enabled
        cur_req = "R8";
        wr(4'd5, 32'hFFFF_FFF8);
        wr(4'd1, (1 << 14) | 32'h1 | 32'h2 | (1 << 10) | (1 << 12) | (1 << 7)); ticks(20);
        chk(pin_oe == 1'b0, "R8", "pin_oe as input", {31'd0, pin_oe}, 32'd0);

        // R10: wake pulses with interrupts masked
        cur_req = "R10";
        wr(4'd2, 32'h7); wr(4'd3, 32'h0); wr(4'd4, 32'h3); wr(4'd8, 32'hFFFF_FFFA);
        wr(4'd5, 32'hFFFF_FFF6); wr(4'd1, 32'h1 | 32'h2 | (1 << 6) | (2 << 10)); ticks(20);
        chk(irq_o == 1'b0, "R10", "no irq with enables clear", {31'd0, irq_o}, 32'd0);

        // R11: trigger-reload register
        cur_req = "R11";
        wr(4'd1, 32'h0); wr(4'd6, 32'h55); wr(4'd7, 32'h0);
        rd(4'd7, v); chk(v == 32'hFFFF_FFFF, "R11", "reload reg read", v, 32'hFFFF_FFFF);
        rd(4'd5, v); chk(v == 32'h55, "R11", "count from load", v, 32'h55);

        // R13: write wins over a coinciding tick
        cur_req = "R13";
        wr(4'd1, 32'h1); tick_en = 1;
        wr(4'd5, 32'h1234); rd(4'd5, v);
        chk(v == 32'h1234, "R13", "count after write with tick", v, 32'h1234);
        for (int i = 0; i < 10; i++) wr(4'd3, 32'h0);
        tick_en = 0;

        // Irregular ticks, divider on, both events armed
        cur_req = "R4";
        wr(4'd3, 32'h3); wr(4'd4, 32'h1); wr(4'd6, 32'hFFFF_FF00); wr(4'd8, 32'hFFFF_FF80);
        wr(4'd5, 32'hFFFF_FF00);
        wr(4'd1, 32'h1 | 32'h2 | (1 << 5) | (1 << 6) | (2 << 10) | (1 << 12));
        for (int i = 0; i < 3000; i++) begin
            tick_en = ($urandom % 3) != 0;
            if (($urandom % 97) == 0) wr(4'd2, 32'h3);
            else @(negedge clk);
        end
        tick_en = 0;

        // R12: soft reset
        cur_req = "R12";
        soft_rst = 1; @(negedge clk); soft_rst = 0;
        rd(4'd1, v); chk(v == 32'd0, "R12", "ctrl after soft reset", v, 32'd0);
        rd(4'd6, v); chk(v == 32'd0, "R12", "load after soft reset", v, 32'd0);
        chk(count_o == 32'd0, "R12", "count after soft reset", count_o, 32'd0);

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule